// File: doc/BRIEF.md
# Packed SIMD Media Execution Unit

This unit executes one family of packed-integer media instructions. Each instruction operates on a small local register file. A 32-bit instruction word arrives together with a valid strobe. The unit checks the group selector and picks the operation from the minor field. It reads two source registers through combinational ports, computes the lane-wise result and writes the destination register on the same clock edge.

A done pulse follows one cycle after every strobe. For an undefined operation inside the group, a reserved-instruction flag is raised along with that done pulse.

There are four operations:
- a full-word conditional negate, with the sign taken from a third register;
- the same conditional negate on two halfwords independently;
- an unsigned byte-wise absolute difference;
- a saturating pack of four signed halfwords into four unsigned bytes.

A separate load port lets the surrounding datapath fill the register file with operands, and a debug read port exposes any register.

Top module: `simd_media_unit`

## Requirements
- R1: All registers read zero after reset, and index 0 always reads zero, even after a load or instruction aimed at it.
- R2: An instruction belongs to the group when bits 5..0 equal 0x07. Bits 20..18 select the operation: 0 is word negate, 2 is halfword negate, 4 is byte absolute difference, 6 is saturating pack. Register fields: destination at bits 9..6, source b at 13..10, source c at 17..14.
- R3: An in-group instruction with an odd operation value (1, 3, 5, 7) writes nothing and raises reserved_o together with done_o.
- R4: The two negate operations need bits 25..21 all zero, and the other two need only bits 23..21 zero. A nonzero padding field turns the instruction into a no-op with no write.
- R5: A destination index of 0 suppresses the write.
- R6: Word negate writes the two's-complement negation of b when c is negative as a signed word, and b unchanged otherwise.
- R7: Halfword negate treats bits 31..16 and 15..0 separately. Each halfword of b is negated, truncated to 16 bits, when the matching halfword of c has its sign bit set.
- R8: Absolute difference writes into each byte the magnitude of the unsigned difference of the matching bytes of b and c.
- R9: Saturating pack clamps each signed halfword to 0..255. High half of b goes to byte 3, low half of b to byte 2, high half of c to byte 1, low half of c to byte 0.
- R10: The write lands on the clock edge where instr_valid_i is high, and done_o is high for exactly the following cycle. An instruction outside the group writes nothing and does not flag reserved.
- R11: The load port writes load_data_i into register load_idx_i on an edge where load_en_i is high and no instruction writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction strobe |
| instr_i | input | 32 | Instruction word |
| load_en_i | input | 1 | Operand load strobe |
| load_idx_i | input | 4 | Load target register |
| load_data_i | input | 32 | Load value |
| dbg_idx_i | input | 4 | Debug read index |
| dbg_data_o | output | 32 | Debug read data |
| done_o | output | 1 | Pulse one cycle after a strobe |
| reserved_o | output | 1 | Reserved-operation flag, valid with done_o |

## Verification
The negate operations are run with a negative, a positive and a zero-index sign source, which separates the sign test from plain copying. They are also run with the most negative word, whose negation wraps back to itself.

Halfword negate uses operands whose two halves disagree in sign, so a lane swap or a carry across halves shows up.

Absolute difference uses bytes at 0x00, 0xFF, 0x7F and 0x80. These values expose signed interpretation and wrong subtraction order.

The pack uses values above 255, negative values, in-range values and the signed extremes, each in a distinct lane, so any clamp error or byte misplacement is visible.

Padding bits just inside and just outside each operation's checked field show which operations check which bits.

// File: rtl/simd_media_pkg.sv
package simd_media_pkg;
  localparam int XLEN  = 32;
  localparam int IDX_W = 4;
  localparam logic [5:0] GROUP_CODE = 6'h07;

  typedef enum logic [2:0] {
    OP_NEG_W  = 3'd0,
    OP_NEG_H  = 3'd2,
    OP_ABSD_B = 3'd4,
    OP_SAT_B  = 3'd6
  } media_op_e;

  typedef struct packed {
    logic             we;
    logic             rsvd;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] src_b;
    logic [IDX_W-1:0] src_c;
    media_op_e        op;
  } media_dec_t;
endpackage

// File: rtl/simd_regfile.sv
module simd_regfile #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [XLEN-1:0]  wr_data_i,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  output logic [XLEN-1:0]  rd_b_o,
  input  logic [IDX_W-1:0] rd_c_idx_i,
  output logic [XLEN-1:0]  rd_c_o,
  input  logic [IDX_W-1:0] dbg_idx_i,
  output logic [XLEN-1:0]  dbg_data_o
);
  localparam int NREG = 1 << IDX_W;

  logic [XLEN-1:0] regs [1:NREG-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 1; i < NREG; i++) regs[i] <= '0;
    end else if (we_i && wr_idx_i != '0) begin
      regs[wr_idx_i] <= wr_data_i;
    end
  end

  function automatic logic [XLEN-1:0] rd(input logic [IDX_W-1:0] idx);
    return (idx == '0) ? '0 : regs[idx];
  endfunction

  assign rd_b_o     = rd(rd_b_idx_i);
  assign rd_c_o     = rd(rd_c_idx_i);
  assign dbg_data_o = rd(dbg_idx_i);

  // R10: a committed write is visible on the next cycle
  assert_wb_lands_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_idx_i != '0) |=> regs[$past(wr_idx_i)] == $past(wr_data_i));
endmodule

// File: rtl/simd_decode.sv
module simd_decode
  import simd_media_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [31:0] instr_i,
  output media_dec_t dec_o
);
  logic       grp_hit;
  logic [2:0] minor;
  logic       known;
  logic       pad_ok;

  assign grp_hit = (instr_i[5:0] == GROUP_CODE);
  assign minor   = instr_i[20:18];

  always_comb begin
    known  = 1'b0;
    pad_ok = 1'b0;
    case (minor)
      OP_NEG_W, OP_NEG_H: begin
        known  = 1'b1;
        pad_ok = (instr_i[25:21] == '0);
      end
      OP_ABSD_B, OP_SAT_B: begin
        known  = 1'b1;
        pad_ok = (instr_i[23:21] == '0);
      end
      default: ;
    endcase
  end

  always_comb begin
    dec_o.dst   = instr_i[9:6];
    dec_o.src_b = instr_i[13:10];
    dec_o.src_c = instr_i[17:14];
    dec_o.op    = media_op_e'(minor);
    dec_o.rsvd  = valid_i && grp_hit && !known;
    dec_o.we    = valid_i && grp_hit && known && pad_ok && (instr_i[9:6] != '0);
  end

  // R4: a negate with any padding bit set never writes
  assert_pad_blocks_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (minor[2] == 1'b0 && instr_i[25:21] != '0) |-> !dec_o.we);
  // R10: foreign group never writes or flags
  assert_foreign_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[5:0] != GROUP_CODE) |-> !(dec_o.we || dec_o.rsvd));
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_media_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  media_op_e       op_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] c_i,
  output logic [XLEN-1:0] res_o
);
  localparam int NH = XLEN / 16;
  localparam int NB = XLEN / 8;

  logic [XLEN-1:0]   neg_w, neg_h, absd_b, sat_b;
  logic [2*XLEN-1:0] bc;

  assign neg_w = c_i[XLEN-1] ? (~b_i + 1'b1) : b_i;
  assign bc    = {b_i, c_i};

  for (genvar h = 0; h < NH; h++) begin : g_half
    logic [15:0] bh;
    assign bh = b_i[16*h +: 16];
    assign neg_h[16*h +: 16] = c_i[16*h + 15] ? (~bh + 16'd1) : bh;
  end

  for (genvar k = 0; k < NB; k++) begin : g_byte
    logic [7:0]  x, y;
    logic [15:0] s;
    assign x = b_i[8*k +: 8];
    assign y = c_i[8*k +: 8];
    assign absd_b[8*k +: 8] = (x >= y) ? (x - y) : (y - x);
    // pack: halfword k of {b,c} -> byte k
    assign s = bc[16*k +: 16];
    assign sat_b[8*k +: 8] = s[15] ? 8'h00 : ((|s[14:8]) ? 8'hFF : s[7:0]);
  end

  always_comb begin
    case (op_i)
      OP_NEG_W:  res_o = neg_w;
      OP_NEG_H:  res_o = neg_h;
      OP_ABSD_B: res_o = absd_b;
      OP_SAT_B:  res_o = sat_b;
      default:   res_o = '0;
    endcase
  end
endmodule

// File: rtl/simd_media_unit.sv
module simd_media_unit
  import simd_media_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             instr_valid_i,
  input  logic [31:0]      instr_i,
  input  logic             load_en_i,
  input  logic [IDX_W-1:0] load_idx_i,
  input  logic [XLEN-1:0]  load_data_i,
  input  logic [IDX_W-1:0] dbg_idx_i,
  output logic [XLEN-1:0]  dbg_data_o,
  output logic             done_o,
  output logic             reserved_o
);
  media_dec_t       dec;
  logic [XLEN-1:0]  op_b, op_c, result;
  logic             rf_we;
  logic [IDX_W-1:0] rf_idx;
  logic [XLEN-1:0]  rf_data;
  logic             done_q, rsvd_q;

  simd_decode i_decode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (instr_valid_i),
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  simd_lane_alu #(.XLEN(XLEN)) i_alu (
    .op_i  (dec.op),
    .b_i   (op_b),
    .c_i   (op_c),
    .res_o (result)
  );

  // instruction write-back has priority over the load port
  assign rf_we   = dec.we || load_en_i;
  assign rf_idx  = dec.we ? dec.dst : load_idx_i;
  assign rf_data = dec.we ? result  : load_data_i;

  simd_regfile #(.XLEN(XLEN), .IDX_W(IDX_W)) i_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (rf_we),
    .wr_idx_i   (rf_idx),
    .wr_data_i  (rf_data),
    .rd_b_idx_i (dec.src_b),
    .rd_b_o     (op_b),
    .rd_c_idx_i (dec.src_c),
    .rd_c_o     (op_c),
    .dbg_idx_i  (dbg_idx_i),
    .dbg_data_o (dbg_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      rsvd_q <= 1'b0;
    end else begin
      done_q <= instr_valid_i;
      rsvd_q <= dec.rsvd;
    end
  end

  assign done_o     = done_q;
  assign reserved_o = rsvd_q;

  assert_done_follows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i |=> done_o);
  assert_no_stray_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |=> !done_o);
  assert_rsvd_with_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reserved_o |-> done_o);
  assert_rsvd_no_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec.rsvd |-> !dec.we);
endmodule

// File: tb/test_simd_media_unit.sv
module test_simd_media_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic        load_en = 1'b0;
  logic [3:0]  load_idx = '0;
  logic [31:0] load_data = '0;
  logic [3:0]  dbg_idx = '0;
  logic [31:0] dbg_data;
  logic        done, reserved;

  int n_checks = 0;
  int n_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  simd_media_unit i_simd_media_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .instr_valid_i(instr_valid), .instr_i(instr),
    .load_en_i(load_en), .load_idx_i(load_idx), .load_data_i(load_data),
    .dbg_idx_i(dbg_idx), .dbg_data_o(dbg_data),
    .done_o(done), .reserved_o(reserved)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [2:0] minor, input logic [3:0] a,
                                     input logic [3:0] b, input logic [3:0] c,
                                     input logic [4:0] pad, input logic [5:0] grp);
    return {6'b0, pad, minor, c, b, a, grp};
  endfunction

  // reference models
  function automatic logic [31:0] m_negw(input logic [31:0] b, input logic [31:0] c);
    return ($signed(c) < 0) ? 32'(0 - b) : b;
  endfunction
  function automatic logic [31:0] m_negh(input logic [31:0] b, input logic [31:0] c);
    logic [31:0] r;
    for (int h = 0; h < 2; h++)
      r[16*h +: 16] = ($signed(c[16*h +: 16]) < 0) ? 16'(0 - b[16*h +: 16]) : b[16*h +: 16];
    return r;
  endfunction
  function automatic logic [31:0] m_absd(input logic [31:0] b, input logic [31:0] c);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) begin
      int d;
      d = int'(b[8*k +: 8]) - int'(c[8*k +: 8]);
      r[8*k +: 8] = 8'(d < 0 ? -d : d);
    end
    return r;
  endfunction
  function automatic logic [7:0] clamp(input logic [15:0] v);
    int s;
    s = int'($signed(v));
    return (s < 0) ? 8'd0 : (s > 255) ? 8'd255 : 8'(s);
  endfunction
  function automatic logic [31:0] m_sat(input logic [31:0] b, input logic [31:0] c);
    return {clamp(b[31:16]), clamp(b[15:0]), clamp(c[31:16]), clamp(c[15:0])};
  endfunction

  task automatic load(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    load_en = 1'b1; load_idx = idx; load_data = val;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic read(input logic [3:0] idx, output logic [31:0] val);
    dbg_idx = idx;
    #1 val = dbg_data;
  endtask

  // issue one instruction; returns done/reserved sampled the cycle after
  task automatic issue(input logic [31:0] w, output logic d, output logic r);
    @(negedge clk);
    instr = w; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    d = done; r = reserved;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 16; i++) begin
      read(4'(i), v);
      check($sformatf("R1 reset reg %0d", i), v, 32'h0);
    end
    check("R10 done low after reset", {31'b0, done}, 32'h0);
    load(4'd0, 32'hDEAD_BEEF);
    read(4'd0, v);
    check("R1 reg0 ignores load", v, 32'h0);
  endtask

  task automatic t_negw;
    logic [31:0] v;
    logic d, r;
    load(4'd1, 32'h0000_1234);
    load(4'd2, 32'h8000_0000);
    load(4'd3, 32'h7FFF_FFFF);
    read(4'd1, v); check("R11 load reg1", v, 32'h0000_1234);
    issue(mk(3'd0, 4'd4, 4'd1, 4'd2, 5'd0, 6'h07), d, r);
    read(4'd4, v); check("R6 negative c negates", v, m_negw(32'h1234, 32'h8000_0000));
    check("R10 done after issue", {31'b0, d}, 32'h1);
    check("R3 no reserved on valid op", {31'b0, r}, 32'h0);
    issue(mk(3'd0, 4'd5, 4'd1, 4'd3, 5'd0, 6'h07), d, r);
    read(4'd5, v); check("R6 positive c copies", v, 32'h0000_1234);
    issue(mk(3'd0, 4'd6, 4'd2, 4'd2, 5'd0, 6'h07), d, r);
    read(4'd6, v); check("R6 min word wraps", v, 32'h8000_0000);
    issue(mk(3'd0, 4'd7, 4'd1, 4'd0, 5'd0, 6'h07), d, r);
    read(4'd7, v); check("R1 zero sign source copies", v, 32'h0000_1234);
  endtask

  task automatic t_negh;
    logic [31:0] v;
    logic d, r;
    load(4'd8, 32'h0005_FFFE);
    load(4'd9, 32'h8000_0001);
    issue(mk(3'd2, 4'd10, 4'd8, 4'd9, 5'd0, 6'h07), d, r);
    read(4'd10, v); check("R7 high neg low keep", v, 32'hFFFB_FFFE);
    load(4'd8, 32'h8000_0003);
    load(4'd9, 32'h0000_FFFF);
    issue(mk(3'd2, 4'd10, 4'd8, 4'd9, 5'd0, 6'h07), d, r);
    read(4'd10, v); check("R7 low neg high keep", v, m_negh(32'h8000_0003, 32'h0000_FFFF));
  endtask

  task automatic t_absd;
    logic [31:0] v;
    logic d, r;
    load(4'd11, 32'h10FF_0080);
    load(4'd12, 32'h2000_FF7F);
    issue(mk(3'd4, 4'd13, 4'd11, 4'd12, 5'd0, 6'h07), d, r);
    read(4'd13, v); check("R8 unsigned bytes", v, m_absd(32'h10FF_0080, 32'h2000_FF7F));
    check("R8 literal", v, 32'h10FF_FF01);
  endtask

  task automatic t_sat;
    logic [31:0] v;
    logic d, r;
    load(4'd14, 32'h0100_FFFF);
    load(4'd15, 32'h007F_0000);
    issue(mk(3'd6, 4'd13, 4'd14, 4'd15, 5'd0, 6'h07), d, r);
    read(4'd13, v); check("R9 clamp and order", v, 32'hFF00_7F00);
    load(4'd14, 32'h8000_00FF);
    load(4'd15, 32'h7FFF_0042);
    issue(mk(3'd6, 4'd13, 4'd14, 4'd15, 5'd0, 6'h07), d, r);
    read(4'd13, v); check("R9 extremes", v, m_sat(32'h8000_00FF, 32'h7FFF_0042));
  endtask

  task automatic t_rsvd;
    logic [31:0] v;
    logic d, r;
    load(4'd4, 32'hA5A5_0001);
    issue(mk(3'd1, 4'd4, 4'd1, 4'd2, 5'd0, 6'h07), d, r);
    check("R3 reserved minor 1", {31'b0, r}, 32'h1);
    check("R3 done with reserved", {31'b0, d}, 32'h1);
    issue(mk(3'd7, 4'd4, 4'd1, 4'd2, 5'd0, 6'h07), d, r);
    check("R3 reserved minor 7", {31'b0, r}, 32'h1);
    read(4'd4, v); check("R3 reserved no write", v, 32'hA5A5_0001);
  endtask

  task automatic t_pad;
    logic [31:0] v;
    logic d, r;
    load(4'd5, 32'h0000_5555);
    load(4'd11, 32'h0000_0010);
    load(4'd12, 32'h0000_0003);
    issue(mk(3'd0, 4'd5, 4'd2, 4'd2, 5'b01000, 6'h07), d, r);
    read(4'd5, v); check("R4 negate pad bit24 no write", v, 32'h0000_5555);
    issue(mk(3'd4, 4'd5, 4'd11, 4'd12, 5'b01000, 6'h07), d, r);
    read(4'd5, v); check("R4 absd bit24 not checked", v, 32'h0000_000D);
    load(4'd5, 32'h0000_5555);
    issue(mk(3'd4, 4'd5, 4'd11, 4'd12, 5'b00010, 6'h07), d, r);
    read(4'd5, v); check("R4 absd pad bit22 no write", v, 32'h0000_5555);
  endtask

  task automatic t_dest0;
    logic [31:0] v;
    logic d, r;
    issue(mk(3'd6, 4'd0, 4'd14, 4'd15, 5'd0, 6'h07), d, r);
    read(4'd0, v); check("R5 dest0 stays zero", v, 32'h0);
    read(4'd5, v); check("R5 other reg untouched", v, 32'h0000_5555);
  endtask

  task automatic t_group;
    logic [31:0] v;
    logic d, r;
    issue(mk(3'd4, 4'd5, 4'd11, 4'd12, 5'd0, 6'h08), d, r);
    read(4'd5, v); check("R2 foreign group no write", v, 32'h0000_5555);
    check("R10 foreign done", {31'b0, d}, 32'h1);
    issue(mk(3'd3, 4'd5, 4'd11, 4'd12, 5'd0, 6'h10), d, r);
    check("R10 foreign no reserved", {31'b0, r}, 32'h0);
    check("R10 done drops", {31'b0, done}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_negw();
    t_negh();
    t_absd();
    t_sat();
    t_rsvd();
    t_pad();
    t_dest0();
    t_group();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule